// File: doc/BRIEF.md
# Soft-Start and Fault Supervisor

This block sequences start-up and recovery after an over-current fault for a phase-shifted bridge controller. It takes three flags that are already digital: a supply-valid flag, a reference-ready flag and a raw over-current comparator output. From these it maintains a digital soft-start level, a fault latch, an output-enable and a clamped phase command for the PWM generator that follows it.

The soft-start level rises slowly by one step every `CHG_DIV` clocks and falls quickly by one step per clock. It replaces the analog soft-start capacitor, and the start, discharge and restart thresholds are fixed levels on it. An over-current event shuts the outputs off. The level is then pulled down to a low floor and recharged. The fault latch can only clear once the recharge reaches the restart level, even if the fault arrived partway through an earlier soft start.

Top module: `ss_supervisor`

## Requirements
- R1: While `supply_ok` is low at a clock edge, after that edge `ss_level` is 0, `fault_latched` is 0 and `out_en` is 0.
- R2: While `vref_ok` is low, the block is held in lockout exactly as in R1, even when `supply_ok` is high.
- R3: Outside lockout, with no fault discharge and no over-current, `ss_level` rises by exactly 1 every `CHG_DIV` (default 6) clocks. It stops at the full value 255. After lockout ends, the level is k after 6k clocks.
- R4: `oc_raw` passes through a two-flop synchronizer. A high level set between edges drives `out_en` low after the second rising edge and sets `fault_latched` after the third. `out_en` is never high while `fault_latched` is high.
- R5: Once a fault is latched, `ss_level` falls by exactly 1 per clock until it reaches the discharge floor `DIS_LVL` (default 16). That is six times the charge rate. From full, with `oc_raw` held, the level reaches 16 at the 242nd edge after `oc_raw` rises.
- R6: While the synchronized over-current stays high, `out_en` stays 0 and `ss_level` never rises.
- R7: `fault_latched` clears only at the clock after `ss_level` has reached `RESTART_LVL` (default 240) with the over-current removed, and the level is then still 240. This holds when the fault struck partway through a soft start. From the floor of 16, with `oc_raw` dropped at a negative edge, it clears at the 1347th rising edge.
- R8: At the first clock after lockout ends, `out_en` is 1 while `ss_level` is still 0, so switching resumes at zero phase.
- R9: `phase_clamp` equals the smaller of `ss_level` and `phase_cmd` when `out_en` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply above the lockout threshold |
| vref_ok | input | 1 | Internal reference is ready |
| oc_raw | input | 1 | Asynchronous over-current comparator output |
| phase_cmd | input | 8 | Phase command from the control loop |
| out_en | output | 1 | Bridge outputs may switch |
| fault_latched | output | 1 | Over-current fault latch state |
| ss_level | output | 8 | Current soft-start level |
| phase_clamp | output | 8 | Phase command limited by the soft-start level |

## Verification
The assertions assume that `supply_ok` and `vref_ok` are glitch-free levels sampled at the clock. They also assume `oc_raw` may change at any time, because the synchronizer absorbs it. The bench drives every input on the falling edge, so each rising edge sees a stable value. Over-current is applied both as short pulses during a soft start and as a long hold from full charge. The random phase keeps lockout events rare, so that charge, discharge and restart sequences have room to run to completion between them.

// File: rtl/ss_supervisor.sv
module ss_supervisor #(
  parameter int LVL_W       = 8,
  parameter int CHG_DIV     = 6,
  parameter int DIS_LVL     = 16,
  parameter int RESTART_LVL = 240
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             vref_ok,
  input  logic             oc_raw,
  input  logic [LVL_W-1:0] phase_cmd,
  output logic             out_en,
  output logic             fault_latched,
  output logic [LVL_W-1:0] ss_level,
  output logic [LVL_W-1:0] phase_clamp
);
  localparam int DIV_W = $clog2(CHG_DIV + 1);
  localparam logic [LVL_W-1:0] FULL    = {LVL_W{1'b1}};
  localparam logic [LVL_W-1:0] FLOOR   = LVL_W'(DIS_LVL);
  localparam logic [LVL_W-1:0] RESTART = LVL_W'(RESTART_LVL);
  localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(CHG_DIV - 1);

  logic             oc_s1, oc_s2;
  logic             lock_q, dis_q, fault_q;
  logic [LVL_W-1:0] lvl_q;
  logic [DIV_W-1:0] div_q;
  logic             lockout, charging;

  assign lockout  = !supply_ok || !vref_ok;
  assign charging = !dis_q && !oc_s2 && (lvl_q != FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_s1   <= 1'b0;
      oc_s2   <= 1'b0;
      lock_q  <= 1'b1;
      dis_q   <= 1'b0;
      fault_q <= 1'b0;
      lvl_q   <= '0;
      div_q   <= '0;
    end else if (lockout) begin
      oc_s1   <= 1'b0;
      oc_s2   <= 1'b0;
      lock_q  <= 1'b1;
      dis_q   <= 1'b0;
      fault_q <= 1'b0;
      lvl_q   <= '0;
      div_q   <= '0;
    end else begin
      oc_s1  <= oc_raw;
      oc_s2  <= oc_s1;
      lock_q <= 1'b0;

      if (oc_s2 && lvl_q > FLOOR)
        dis_q <= 1'b1;
      else if (dis_q && lvl_q <= FLOOR)
        dis_q <= 1'b0;

      if (dis_q && lvl_q > FLOOR) begin
        lvl_q <= lvl_q - 1'b1;
        div_q <= '0;
      end else if (charging) begin
        if (div_q == DIV_TOP) begin
          div_q <= '0;
          lvl_q <= lvl_q + 1'b1;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end else begin
        div_q <= '0;
      end

      if (oc_s2)
        fault_q <= 1'b1;
      else if (fault_q && !dis_q && lvl_q >= RESTART)
        fault_q <= 1'b0;
    end
  end

  assign out_en        = !lock_q && !fault_q && !oc_s2;
  assign fault_latched = fault_q;
  assign ss_level      = lvl_q;
  assign phase_clamp   = !out_en ? '0 : (lvl_q < phase_cmd ? lvl_q : phase_cmd);
endmodule

// File: rtl/ss_supervisor_chk.sv
module ss_supervisor_chk #(
  parameter int LVL_W       = 8,
  parameter int RESTART_LVL = 240
) (
  input logic             clk,
  input logic             rst_n,
  input logic             supply_ok,
  input logic             vref_ok,
  input logic             lock_q,
  input logic [LVL_W-1:0] phase_cmd,
  input logic             out_en,
  input logic             fault_latched,
  input logic [LVL_W-1:0] ss_level,
  input logic [LVL_W-1:0] phase_clamp
);
  a_r1_lockout_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (ss_level == '0 && !fault_latched && !out_en));

  a_r2_vref_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    !vref_ok |=> (!out_en && ss_level == '0));

  a_r3_rise_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_level > $past(ss_level)) |-> (ss_level == $past(ss_level) + 1'b1));

  a_r4_fault_blocks_out: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched |-> !out_en);

  a_r5_fall_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_level < $past(ss_level) && !lock_q) |-> (ss_level == $past(ss_level) - 1'b1));

  a_r7_clear_at_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fault_latched) && !lock_q) |-> (ss_level >= LVL_W'(RESTART_LVL)));

  a_r9_clamp_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_clamp <= ss_level) && (phase_clamp <= phase_cmd));
endmodule

bind ss_supervisor ss_supervisor_chk #(
  .LVL_W(LVL_W), .RESTART_LVL(RESTART_LVL)
) chk_i (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .vref_ok(vref_ok),
  .lock_q(lock_q), .phase_cmd(phase_cmd), .out_en(out_en),
  .fault_latched(fault_latched), .ss_level(ss_level), .phase_clamp(phase_clamp)
);

// File: tb/ss_supervisor_tb.sv
module ss_supervisor_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       supply_ok = 1'b0, vref_ok = 1'b0, oc_raw = 1'b0;
  logic [7:0] phase_cmd = '0;
  logic       out_en, fault_latched;
  logic [7:0] ss_level, phase_clamp;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ss_supervisor dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .vref_ok(vref_ok),
    .oc_raw(oc_raw), .phase_cmd(phase_cmd), .out_en(out_en),
    .fault_latched(fault_latched), .ss_level(ss_level), .phase_clamp(phase_clamp)
  );

  function automatic logic [7:0] exp_clamp(logic en, logic [7:0] lvl, logic [7:0] cmd);
    if (!en) return 8'd0;
    return (lvl < cmd) ? lvl : cmd;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    int n;
    logic [7:0] l0;
    void'($urandom(32'h5EED1));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ss_level == 0 && !out_en && !fault_latched, "R1 reset", ss_level, 0);

    supply_ok = 1'b1;
    repeat (10) @(negedge clk);
    check(ss_level == 0, "R2 level", ss_level, 0);
    check(!out_en, "R2 out_en", out_en, 0);

    vref_ok = 1'b1;
    phase_cmd = 8'd200;
    @(negedge clk);
    check(out_en && ss_level == 0, "R8 enable at zero", {out_en, ss_level}, 256);
    check(phase_clamp == 0, "R8 clamp", phase_clamp, 0);
    repeat (5) @(negedge clk);
    check(ss_level == 1, "R3 first step", ss_level, 1);
    repeat (54) @(negedge clk);
    check(ss_level == 10, "R3 tenth step", ss_level, 10);

    n = 0;
    while (ss_level < 100 && n < 2000) begin
      phase_cmd = 8'($urandom);
      @(negedge clk);
      check(phase_clamp == exp_clamp(out_en, ss_level, phase_cmd), "R9 clamp",
            phase_clamp, exp_clamp(out_en, ss_level, phase_cmd));
      n++;
    end

    // fault partway through soft start
    oc_raw = 1'b1;
    @(negedge clk);
    check(out_en, "R4 one edge", out_en, 1);
    @(negedge clk);
    check(!out_en, "R4 out off", out_en, 0);
    check(!fault_latched, "R4 latch not yet", fault_latched, 0);
    @(negedge clk);
    check(fault_latched, "R4 latch set", fault_latched, 1);
    oc_raw = 1'b0;
    @(negedge clk);
    l0 = ss_level;
    @(negedge clk);
    check(ss_level == l0 - 8'd1, "R5 fall step", ss_level, l0 - 8'd1);
    n = 0;
    while (ss_level != 16 && n < 300) begin @(negedge clk); n++; end
    check(ss_level == 16, "R5 floor", ss_level, 16);
    n = 0;
    while (fault_latched && n < 3000) begin
      if (out_en) check(0, "R4 out while fault", out_en, 0);
      @(negedge clk);
      n++;
    end
    check(!fault_latched && ss_level == 240, "R7 clear at restart", ss_level, 240);

    n = 0;
    while (ss_level != 255 && n < 300) begin @(negedge clk); n++; end
    repeat (12) @(negedge clk);
    check(ss_level == 255, "R3 hold full", ss_level, 255);

    // persistent over-current from full
    oc_raw = 1'b1;
    n = 0;
    while (ss_level != 16 && n < 400) begin @(negedge clk); n++; end
    check(n == 242, "R5 discharge edges", n, 242);
    repeat (50) @(negedge clk);
    check(ss_level == 16 && !out_en, "R6 held off", ss_level, 16);
    check(fault_latched, "R6 latch", fault_latched, 1);

    oc_raw = 1'b0;
    n = 0;
    while (fault_latched && n < 3000) begin @(negedge clk); n++; end
    check(n == 1347, "R7 restart edges", n, 1347);
    check(ss_level == 240 && out_en, "R7 level at clear", ss_level, 240);

    // lockout entry resets state
    oc_raw = 1'b1;
    repeat (3) @(negedge clk);
    supply_ok = 1'b0;
    oc_raw = 1'b0;
    @(negedge clk);
    check(ss_level == 0 && !fault_latched && !out_en, "R1 lockout entry",
          {fault_latched, out_en, ss_level}, 0);
    supply_ok = 1'b1;
    vref_ok = 1'b0;
    repeat (4) @(negedge clk);
    check(ss_level == 0 && !out_en, "R2 vref hold", ss_level, 0);
    vref_ok = 1'b1;

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] prev;
      logic sup_prev;
      prev = ss_level;
      phase_cmd = 8'($urandom);
      if ($urandom_range(0, 199) == 0) oc_raw = 1'b1;
      else if ($urandom_range(0, 3) == 0) oc_raw = 1'b0;
      supply_ok = ($urandom_range(0, 999) != 0);
      sup_prev = supply_ok;
      @(negedge clk);
      check(phase_clamp == exp_clamp(out_en, ss_level, phase_cmd), "R9 random clamp",
            phase_clamp, exp_clamp(out_en, ss_level, phase_cmd));
      if (fault_latched && out_en) check(0, "R4 random fault", out_en, 0);
      if (!sup_prev) check(ss_level == 0, "R1 random lockout", ss_level, 0);
      else if (ss_level > prev + 8'd1 || (ss_level + 8'd1 < prev))
        check(0, "R3 random step", ss_level, prev);
    end

    done = 1'b1;
    finish_run();
  end
endmodule